// File: doc/BRIEF.md
# Five-Step Repeating Branch Outcome Predictor

This block supplies a taken/not-taken guess for conditional branches by replaying one fixed outcome sequence of period five: taken, not-taken, taken, taken, not-taken. It never sees real branch results. Each cycle in which the branch strobe is high uses up one step of the sequence. While the strobe is low the step is held.

The guess is available on the cycle before the strobe edge that consumes it. A front end samples the guess alongside the strobe, and the sequencer moves to the next step at that same edge. The sequence is set by a parameter vector. Its default encodes the five-step pattern above.

Top module: `pattern_bpred`

## Requirements
- R1: After synchronous reset the step index is 0 and the prediction is 1 (taken).
- R2: The prediction is 1 for taken and 0 for not-taken. From reset, with one strobe per branch, the predictions follow 1,0,1,1,0 and repeat with period five.
- R3: A rising clock edge with the strobe low leaves the step index unchanged, so the prediction is unchanged.
- R4: After the step at index 4 has been consumed, the index wraps back to 0. The next prediction is again 1.
- R5: Over whole periods of the repeating true pattern, every prediction is correct (100% accuracy).
- R6: Over whole periods of the bitwise-complement pattern, every prediction is wrong (0% accuracy).
- R7: Reset asserted mid-sequence returns the index to 0 at the next edge, whether or not the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | High when the current instruction is a conditional branch; consumes one step |
| pred_taken | output | 1 | Guess for the current branch: 1 taken, 0 not-taken |

## Verification
The hardest state to reach is the wrap from index 4 to 0 while idle cycles are mixed in. The stimulus scatters strobe-low gaps between branches across several periods, so every step is held at least once before it is consumed. The stimulus also asserts reset while the strobe is high at a non-zero index, so reset must win over the advance.

// File: rtl/pattern_bpred_pkg.sv
package pattern_bpred_pkg;
  localparam int unsigned PERIOD = 5;
  localparam logic [PERIOD-1:0] DEFAULT_SEQ = 5'b01101; // bit i = guess at step i
endpackage

// File: rtl/pattern_step_ctr.sv
module pattern_step_ctr #(
  parameter int unsigned PERIOD = 5,
  localparam int unsigned IW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] idx
);
  localparam logic [IW-1:0] LAST = IW'(PERIOD - 1);
  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (adv)  idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/pattern_lookup.sv
module pattern_lookup #(
  parameter int unsigned PERIOD = 5,
  parameter logic [PERIOD-1:0] SEQ = '0,
  localparam int unsigned IW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic [IW-1:0] idx,
  output logic          bit_out
);
  always_comb begin
    bit_out = 1'b0;
    for (int i = 0; i < int'(PERIOD); i++)
      if (idx == IW'(i)) bit_out = SEQ[i];
  end
endmodule

// File: rtl/pattern_bpred.sv
module pattern_bpred
  import pattern_bpred_pkg::*;
#(
  parameter int unsigned N_STEPS = PERIOD,
  parameter logic [N_STEPS-1:0] SEQ = DEFAULT_SEQ
) (
  input  logic clk,
  input  logic rst,
  input  logic br_valid,
  output logic pred_taken
);
  localparam int unsigned IW = (N_STEPS > 1) ? $clog2(N_STEPS) : 1;
  logic [IW-1:0] step_idx;

  pattern_step_ctr #(.PERIOD(N_STEPS)) u_ctr (
    .clk(clk), .rst(rst), .adv(br_valid), .idx(step_idx)
  );
  pattern_lookup #(.PERIOD(N_STEPS), .SEQ(SEQ)) u_lut (
    .idx(step_idx), .bit_out(pred_taken)
  );
endmodule

// File: rtl/pattern_bpred_chk.sv
module pattern_bpred_chk #(
  parameter int unsigned IW = 3,
  parameter int unsigned N_STEPS = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          br_valid,
  input logic          pred_taken,
  input logic [IW-1:0] step_idx
);
  logic seen;
  always_ff @(posedge clk) seen <= 1'b1;

  a_r1_reset_idx: assert property (@(posedge clk) disable iff (!seen)
    rst |=> (step_idx == '0 && pred_taken));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst || !seen)
    !br_valid |=> $stable(step_idx));
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst || !seen)
    (br_valid && step_idx == IW'(N_STEPS-1)) |=> step_idx == '0);
  a_r2_advance: assert property (@(posedge clk) disable iff (rst || !seen)
    (br_valid && step_idx != IW'(N_STEPS-1)) |=> step_idx == $past(step_idx) + 1'b1);
  a_r2_range: assert property (@(posedge clk) disable iff (rst || !seen)
    step_idx < IW'(N_STEPS));
endmodule

bind pattern_bpred pattern_bpred_chk #(.IW(IW), .N_STEPS(N_STEPS)) u_chk (
  .clk(clk), .rst(rst), .br_valid(br_valid), .pred_taken(pred_taken), .step_idx(step_idx)
);

// File: tb/sim_pattern_bpred.sv
`timescale 1ns/1ps
module sim_pattern_bpred;
  logic clk = 0, rst = 1, br_valid = 0;
  logic pred_taken;
  int checks = 0, errors = 0;
  localparam logic [4:0] GOLD = 5'b01101;

  always #2.5 clk = ~clk;

  pattern_bpred u0 (.clk(clk), .rst(rst), .br_valid(br_valid), .pred_taken(pred_taken));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic tick(input logic r, input logic v);
    rst = r; br_valid = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    tick(1, 0); tick(0, 0);
    chk("R1 reset guess", pred_taken, 1'b1);
  endtask

  task automatic t_sequence;
    for (int k = 0; k < 10; k++) begin
      chk("R2 step guess", pred_taken, GOLD[k % 5]);
      tick(0, 1);
    end
  endtask

  task automatic t_hold;
    tick(1, 0); tick(0, 1); // index 1, guess 0
    for (int k = 0; k < 3; k++) begin
      tick(0, 0);
      chk("R3 hold", pred_taken, 1'b0);
    end
  endtask

  task automatic t_wrap;
    tick(1, 0);
    for (int k = 0; k < 4; k++) tick(0, 1);
    chk("R4 at index4", pred_taken, 1'b0);
    tick(0, 0);
    chk("R4 idle at index4", pred_taken, 1'b0);
    tick(0, 1);
    chk("R4 wrapped", pred_taken, 1'b1);
  endtask

  task automatic t_accuracy;
    int hit_t, hit_c;
    hit_t = 0; hit_c = 0;
    tick(1, 0); tick(0, 0);
    for (int k = 0; k < 20; k++) begin
      if (pred_taken == GOLD[k % 5]) hit_t++;
      if (pred_taken == ~GOLD[k % 5]) hit_c++;
      tick(0, 1);
      if (k % 3 == 1) tick(0, 0);
    end
    checks++;
    if (hit_t != 20) begin errors++; $display("FAIL R5 hits actual=%0d expected=20", hit_t); end
    checks++;
    if (hit_c != 0) begin errors++; $display("FAIL R6 hits actual=%0d expected=0", hit_c); end
  endtask

  task automatic t_mid_reset;
    tick(1, 0); tick(0, 1); tick(0, 1); tick(0, 1); // index 3 guess 1
    chk("R7 pre index3", pred_taken, 1'b1);
    tick(0, 1); // index 4 guess 0
    chk("R7 pre index4", pred_taken, 1'b0);
    tick(1, 1);
    chk("R7 reset wins", pred_taken, 1'b1);
    tick(0, 1);
    chk("R7 after reset step1", pred_taken, 1'b0);
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_hold();
    t_wrap();
    t_accuracy();
    t_mid_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule